// File: doc/BRIEF.md
# Banked Indirect File Address Resolver

This block turns a 5-bit file field from an instruction into a physical address for a banked register file. A non-zero field is a direct access, and it always lands in bank 0. A field of zero starts an indirect access: the pointer register supplies both the bank number and the offset within the bank. In every bank except bank 0, the sixteen lowest offsets are shared with bank 0. Only the upper sixteen offsets of each bank are separate storage.

The block holds the pointer register, which sits at file address 04h, and a flat byte store indexed by the physical address. It gives out the resolved address, the write enable for the file and a combinational read-data mux. The parameter `BANK_BITS` sets how many pointer bits above bit 4 act as the bank number: 0, 2 or 3. Pointer bits above the implemented ones always read as 1. An indirect access whose pointer offset is zero reads as 00h and writes nothing.

Top module: `bank_file_addr`

## Requirements
- R1: When `fa_i` is non-zero, the access is direct and `phys_addr_o` equals `fa_i` zero-extended (bank 0), whatever the pointer holds.
- R2: When `fa_i` is 00h, the access is indirect and uses the implemented pointer bits as the target. A pointer value of 04h therefore reaches the pointer register itself.
- R3: In an indirect access, when pointer bit 4 is 0 (offset 00h to 0Fh), `phys_addr_o` is that 5-bit offset in bank 0, for any bank number.
- R4: In an indirect access, when pointer bit 4 is 1, `phys_addr_o` is {bank bits, pointer bits 4:0}. Each bank's upper sixteen offsets are therefore separate storage.
- R5: An indirect read whose pointer bits 4:0 are zero returns 00h.
- R6: An indirect write whose pointer bits 4:0 are zero leaves `mem_we_o` low and changes no stored value.
- R7: Reading file address 04h returns the pointer. Bits at position 5+BANK_BITS and above read as 1, so after the pointer is written with 00h it reads 80h when BANK_BITS=2.
- R8: A write with `wr_en_i` high takes effect at the rising clock edge. `mem_we_o` is high in that cycle, and the new value is visible to reads in the cycle after.
- R9: When `rd_en_i` is low, `rd_data_o` is 00h.
- R10: A synchronous active-high reset clears the pointer and the store. After reset, address 04h reads 80h and other locations read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fa_i | input | 5 | File address field from the instruction |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 8 | Write data |
| phys_addr_o | output | BANK_BITS+5 | Resolved physical address |
| rd_data_o | output | 8 | Read data |
| mem_we_o | output | 1 | Write enable after null-write suppression |

## Verification
On every cycle, the assertions check the address rules: a direct access stays in bank 0, low offsets alias to bank 0, and high offsets carry the bank number. They also check that a null indirect access never raises the write enable or returns data, that the unimplemented pointer bits stay at 1, and that a pointer write is seen in the next cycle. Other behaviour depends on what is stored, so only the bench scenarios can show it. These cover a value written through one bank that reads back through an aliased bank, bank 0 upper storage staying separate from bank 1, a pointer reached by pointing indirectly at itself, and the stored data left unchanged by a suppressed write.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int unsigned FA_W = 5;
    localparam int unsigned OFS_W = 4;
    localparam logic [FA_W-1:0] INDIRECT_FA = 5'h00;
    localparam logic [FA_W-1:0] PTR_FA = 5'h04;

    typedef enum logic [1:0] {
        SRC_NULL = 2'd0,
        SRC_PTR  = 2'd1,
        SRC_FILE = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic    indirect;
        rd_src_e src;
    } access_t;

    function automatic logic [7:0] impl_mask(input int unsigned pa_w);
        return 8'((64'd1 << pa_w) - 64'd1);
    endfunction

endpackage

// File: rtl/bank_addr_resolve.sv
module bank_addr_resolve
    import bank_pkg::*;
#(
    parameter int unsigned PA_W = 7
) (
    input  logic [FA_W-1:0] fa,
    input  logic [PA_W-1:0] ptr_idx,
    output logic [PA_W-1:0] phys,
    output access_t         acc
);
    logic [PA_W-1:0] ind_addr;

    always_comb begin
        if (ptr_idx[OFS_W])
            ind_addr = ptr_idx;
        else
            ind_addr = PA_W'(ptr_idx[FA_W-1:0]);
    end

    always_comb begin
        acc.indirect = (fa == INDIRECT_FA);
        phys = acc.indirect ? ind_addr : PA_W'(fa);
        if (phys == '0)
            acc.src = SRC_NULL;
        else if (phys == PA_W'(PTR_FA))
            acc.src = SRC_PTR;
        else
            acc.src = SRC_FILE;
    end
endmodule

// File: rtl/bank_ptr_reg.sv
module bank_ptr_reg
    import bank_pkg::*;
#(
    parameter int unsigned PA_W   = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rb,
    output logic [PA_W-1:0]   idx
);
    localparam logic [DATA_W-1:0] MASK = DATA_W'(impl_mask(PA_W));

    logic [DATA_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (we)
            ptr_q <= wdata;
    end

    assign rb  = ptr_q | ~MASK;
    assign idx = rb[PA_W-1:0];
endmodule

// File: rtl/bank_file_store.sv
module bank_file_store #(
    parameter int unsigned PA_W   = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PA_W-1:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << PA_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/bank_file_addr.sv
module bank_file_addr
    import bank_pkg::*;
#(
    parameter int unsigned BANK_BITS = 2,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned PA_W     = BANK_BITS + FA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FA_W-1:0]   fa_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [PA_W-1:0]   phys_addr_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mem_we_o
);
    logic [DATA_W-1:0] ptr_rb;
    logic [PA_W-1:0]   ptr_idx;
    logic [DATA_W-1:0] file_rdata;
    access_t           acc;
    logic              ptr_we;
    logic              file_we;
    logic [DATA_W-1:0] mux_data;

    bank_addr_resolve #(.PA_W(PA_W)) u_resolve (
        .fa      (fa_i),
        .ptr_idx (ptr_idx),
        .phys    (phys_addr_o),
        .acc     (acc)
    );

    bank_ptr_reg #(.PA_W(PA_W), .DATA_W(DATA_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .we    (ptr_we),
        .wdata (wr_data_i),
        .rb    (ptr_rb),
        .idx   (ptr_idx)
    );

    bank_file_store #(.PA_W(PA_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (file_we),
        .addr  (phys_addr_o),
        .wdata (wr_data_i),
        .rdata (file_rdata)
    );

    assign ptr_we   = wr_en_i && (acc.src == SRC_PTR);
    assign file_we  = wr_en_i && (acc.src == SRC_FILE);
    assign mem_we_o = ptr_we || file_we;

    always_comb begin
        case (acc.src)
            SRC_PTR:  mux_data = ptr_rb;
            SRC_FILE: mux_data = file_rdata;
            default:  mux_data = '0;
        endcase
        rd_data_o = rd_en_i ? mux_data : '0;
    end
endmodule

// File: rtl/bank_file_addr_chk.sv
module bank_file_addr_chk
    import bank_pkg::*;
#(
    parameter int unsigned PA_W   = 7,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [FA_W-1:0]   fa_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [PA_W-1:0]   phys_addr_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              mem_we_o,
    input logic [DATA_W-1:0] ptr_rb
);
    localparam logic [DATA_W-1:0] MASK = DATA_W'(impl_mask(PA_W));

    a_r1_direct_bank0: assert property (@(posedge clk) disable iff (rst)
        (fa_i != INDIRECT_FA) |-> ((phys_addr_o >> FA_W) == '0 && phys_addr_o[FA_W-1:0] == fa_i));

    a_r3_low_alias: assert property (@(posedge clk) disable iff (rst)
        (fa_i == INDIRECT_FA && !ptr_rb[OFS_W]) |-> ((phys_addr_o >> OFS_W) == '0));

    a_r4_high_bank: assert property (@(posedge clk) disable iff (rst)
        (fa_i == INDIRECT_FA && ptr_rb[OFS_W]) |->
            (phys_addr_o[OFS_W] && (phys_addr_o >> FA_W) == (ptr_rb[PA_W-1:0] >> FA_W)));

    a_r5_null_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (fa_i == INDIRECT_FA && ptr_rb[FA_W-1:0] == '0) |-> (rd_data_o == '0));

    a_r6_null_no_write: assert property (@(posedge clk) disable iff (rst)
        (fa_i == INDIRECT_FA && ptr_rb[FA_W-1:0] == '0) |-> !mem_we_o);

    a_r7_unimpl_ones: assert property (@(posedge clk) disable iff (rst)
        ((ptr_rb | MASK) == '1));

    a_r8_ptr_write_seen: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && phys_addr_o == PA_W'(PTR_FA)) |=> ((ptr_rb & MASK) == ($past(wr_data_i) & MASK)));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |-> (rd_data_o == '0));
endmodule

bind bank_file_addr bank_file_addr_chk #(.PA_W(PA_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fa_i        (fa_i),
    .rd_en_i     (rd_en_i),
    .wr_data_i   (wr_data_i),
    .phys_addr_o (phys_addr_o),
    .rd_data_o   (rd_data_o),
    .mem_we_o    (mem_we_o),
    .ptr_rb      (ptr_rb)
);

// File: tb/sim_bank_file_addr.sv
`timescale 1ns/1ps
module sim_bank_file_addr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] fa_i = 5'h00;
    logic       rd_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [6:0] phys_addr_o;
    logic [7:0] rd_data_o;
    logic       mem_we_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_file_addr #(.BANK_BITS(2), .DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .fa_i(fa_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .phys_addr_o(phys_addr_o), .rd_data_o(rd_data_o),
        .mem_we_o(mem_we_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] fa, input logic [7:0] d);
        @(negedge clk);
        fa_i = fa; wr_data_i = d; wr_en_i = 1'b1; rd_en_i = 1'b0;
        @(posedge clk);
        #1 wr_en_i = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] fa);
        @(negedge clk);
        fa_i = fa; rd_en_i = 1'b1; wr_en_i = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_read(5'h04);
        chk("R10 pointer after reset", rd_data_o, 8'h80);
        chk("R1 phys of 04h", phys_addr_o, 7'h04);
        do_read(5'h09);
        chk("R10 store after reset", rd_data_o, 8'h00);
        chk("R10 no write", mem_we_o, 0);
    endtask

    task automatic t_direct();
        do_write(5'h07, 8'h5A);
        do_write(5'h10, 8'h11);
        do_read(5'h07);
        chk("R8 direct readback 07h", rd_data_o, 8'h5A);
        do_read(5'h10);
        chk("R8 direct readback 10h", rd_data_o, 8'h11);
    endtask

    task automatic t_bank1_high();
        do_write(5'h04, 8'h30);
        do_read(5'h04);
        chk("R7 pointer 30h reads", rd_data_o, 8'hB0);
        do_read(5'h00);
        chk("R4 bank1 phys", phys_addr_o, 7'h30);
        chk("R4 bank1 initial", rd_data_o, 8'h00);
        @(negedge clk);
        fa_i = 5'h00; wr_data_i = 8'hA5; wr_en_i = 1'b1; rd_en_i = 1'b0;
        #1 chk("R8 we during indirect write", mem_we_o, 1);
        @(posedge clk);
        #1 wr_en_i = 1'b0;
        do_read(5'h00);
        chk("R4 bank1 readback", rd_data_o, 8'hA5);
        do_read(5'h10);
        chk("R4 bank0 upper distinct", rd_data_o, 8'h11);
    endtask

    task automatic t_alias();
        do_write(5'h04, 8'h67);
        do_read(5'h00);
        chk("R3 bank3 low phys", phys_addr_o, 7'h07);
        chk("R3 bank3 low alias data", rd_data_o, 8'h5A);
        do_write(5'h04, 8'h28);
        do_write(5'h00, 8'hC3);
        do_read(5'h08);
        chk("R3 aliased write lands in bank0", rd_data_o, 8'hC3);
    endtask

    task automatic t_null();
        do_write(5'h04, 8'h20);
        do_read(5'h00);
        chk("R5 null read bank1", rd_data_o, 8'h00);
        @(negedge clk);
        fa_i = 5'h00; wr_data_i = 8'h33; wr_en_i = 1'b1; rd_en_i = 1'b0;
        #1 chk("R6 null write enable", mem_we_o, 0);
        @(posedge clk);
        #1 wr_en_i = 1'b0;
        do_read(5'h04);
        chk("R6 pointer untouched", rd_data_o, 8'hA0);
        do_read(5'h00);
        chk("R6 null location still zero", rd_data_o, 8'h00);
        do_write(5'h04, 8'h00);
        do_read(5'h00);
        chk("R5 null read ptr 00h", rd_data_o, 8'h00);
    endtask

    task automatic t_unimpl();
        do_write(5'h04, 8'hFF);
        do_read(5'h04);
        chk("R7 pointer FFh", rd_data_o, 8'hFF);
        do_read(5'h00);
        chk("R4 bank3 top phys", phys_addr_o, 7'h7F);
        do_read(5'h12);
        chk("R1 direct ignores bank", phys_addr_o, 7'h12);
        do_write(5'h04, 8'h00);
        do_read(5'h04);
        chk("R7 cleared pointer reads 80h", rd_data_o, 8'h80);
    endtask

    task automatic t_self_ptr();
        do_write(5'h04, 8'h04);
        do_read(5'h00);
        chk("R2 indirect reaches pointer", rd_data_o, 8'h84);
        do_write(5'h00, 8'h3F);
        do_read(5'h04);
        chk("R2 indirect pointer write", rd_data_o, 8'hBF);
    endtask

    task automatic t_rd_idle();
        @(negedge clk);
        fa_i = 5'h07; rd_en_i = 1'b0; wr_en_i = 1'b0;
        #1 chk("R9 idle read", rd_data_o, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_direct();
        t_bank1_high();
        t_alias();
        t_null();
        t_unimpl();
        t_self_ptr();
        t_rd_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule